// File: doc/BRIEF.md
# Rotating-Parity Small-Write Engine

This block turns one logical word access on a striped disk array with rotating parity into the physical disk operations it needs. A request names a stripe, a data slot within that stripe and, for writes, the new word. The block locates the disk that holds the stripe's parity and maps the slot onto a physical disk. It then runs the read-modify-write on a set of per-disk request/acknowledge ports. The old data word and the old parity word are fetched together. Once both have come back, the new data word and the new parity word are written.

A degraded mode covers one failed disk. A read that targets the failed disk rebuilds the word by XORing every surviving disk in the stripe. A write that targets the failed disk updates only the parity word. If the parity disk itself has failed, a write stores only the data word. The block accepts one operation at a time. It ends each operation with a single completion pulse, and for reads the recovered word comes with that pulse.

Top module: `raid5_rmw_engine`

## Requirements
- R1: The parity disk of a stripe is NDISK-1 minus (stripe mod NDISK). With 5 disks: stripe 0 uses disk 4, stripe 3 uses disk 1 and stripe 5 uses disk 4.
- R2: Data slot k maps to physical disk k when k is below the parity disk, and to disk k+1 otherwise.
- R3: Without a failure, a write raises exactly two reads together (data disk and parity disk) and then exactly two writes to the same two disks.
- R4: No write request is raised before every read response of the operation has returned.
- R5: A normal write stores the new word on the data disk and old data XOR old parity XOR new data on the parity disk.
- R6: `cmd_ready` is low from the cycle after acceptance until completion. A `cmd_valid` held while busy is ignored. Each operation gives exactly one one-cycle `cmd_done`.
- R7: A read of a healthy disk requests only that disk and returns its word on `cmd_rdata` with `cmd_done`.
- R8: In degraded mode, a read whose target is the failed disk reads every other disk and returns their XOR.
- R9: In degraded mode, a write whose target is the failed disk reads the surviving data disks and writes only the parity disk, with their XOR XOR the new data.
- R10: In degraded mode with the parity disk failed, a write raises no reads and writes only the data disk.
- R11: While degraded mode is on, the failed disk is never requested.
- R12: After reset `cmd_ready` is 1 and `disk_req` and `cmd_done` are 0. A disk request stays raised with an unchanged direction (`disk_we`, 1 = write) until that disk acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Operation request |
| cmd_ready | output | 1 | Engine idle, request accepted on this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_stripe | input | STRIPE_W | Stripe number (row on every disk) |
| cmd_slot | input | SLOT_W | Logical data slot in the stripe |
| cmd_wdata | input | WORD_W | New data word for writes |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | WORD_W | Read result, valid with cmd_done |
| deg_en | input | 1 | Degraded mode on |
| deg_disk | input | DSK_W | Index of the failed physical disk |
| disk_req | output | NDISK | Per-disk request, held until acknowledged |
| disk_we | output | 1 | Direction of the raised requests, 1 = write |
| disk_row | output | STRIPE_W | Row addressed on every disk |
| disk_wdata | output | NDISK*WORD_W | Write word per disk, disk i at bits i*WORD_W |
| disk_ack | input | NDISK | Per-disk acknowledge pulse |
| disk_rdata | input | NDISK*WORD_W | Read word per disk, valid with its acknowledge |

## Verification
The checker watches every cycle for these properties: an idle engine is quiet on the disk ports, completion pulses are single, requests are held with a stable direction until acknowledged, writes never start while a read is outstanding, a healthy array never touches more than two disks, and a failed disk is never touched. Only the bench scenarios can show that the parity lands on the right disk for each stripe, that the slot skips it, and that the written parity and rebuilt words carry the right XOR values. They also show that a refused request leaves the disk contents alone. The bench shows these by keeping a shadow copy of the array and comparing it with what the disk models hold after each operation.

// File: rtl/raid5_rmw_pkg.sv
package raid5_rmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/raid5_layout.sv
module raid5_layout #(
  parameter int NDISK    = 5,
  parameter int STRIPE_W = 16,
  localparam int DSK_W   = $clog2(NDISK),
  localparam int SLOT_W  = (NDISK > 2) ? $clog2(NDISK - 1) : 1
) (
  input  logic [STRIPE_W-1:0] stripe,
  input  logic [SLOT_W-1:0]   slot,
  output logic [DSK_W-1:0]    par_disk,
  output logic [DSK_W-1:0]    data_disk
);
  logic [STRIPE_W-1:0] rem;
  logic [DSK_W-1:0]    slot_ext;

  always_comb begin
    rem       = stripe % STRIPE_W'(NDISK);
    par_disk  = DSK_W'(NDISK - 1) - DSK_W'(rem);
    slot_ext  = DSK_W'(slot);
    data_disk = (slot_ext < par_disk) ? slot_ext : slot_ext + DSK_W'(1);
  end
endmodule

// File: rtl/raid5_opplan.sv
module raid5_opplan #(
  parameter int NDISK  = 5,
  localparam int DSK_W = $clog2(NDISK)
) (
  input  logic              is_write,
  input  logic              deg_en,
  input  logic [DSK_W-1:0]  deg_disk,
  input  logic [DSK_W-1:0]  par_disk,
  input  logic [DSK_W-1:0]  data_disk,
  output logic [NDISK-1:0]  rd_mask,
  output logic [NDISK-1:0]  wr_mask
);
  localparam logic [NDISK-1:0] ALL = '1;
  logic [NDISK-1:0] oh_par, oh_dat;
  logic             lost_par, lost_dat;

  always_comb begin
    oh_par   = NDISK'(1) << par_disk;
    oh_dat   = NDISK'(1) << data_disk;
    lost_par = deg_en && (deg_disk == par_disk);
    lost_dat = deg_en && (deg_disk == data_disk);
    rd_mask  = '0;
    wr_mask  = '0;
    if (!is_write) begin
      rd_mask = lost_dat ? (ALL & ~oh_dat) : oh_dat;
    end else if (lost_par) begin
      wr_mask = oh_dat;
    end else if (lost_dat) begin
      rd_mask = ALL & ~oh_dat & ~oh_par;
      wr_mask = oh_par;
    end else begin
      rd_mask = oh_dat | oh_par;
      wr_mask = oh_dat | oh_par;
    end
  end
endmodule

// File: rtl/raid5_xorfold.sv
module raid5_xorfold #(
  parameter int NDISK  = 5,
  parameter int WORD_W = 32
) (
  input  logic [NDISK-1:0]        sel,
  input  logic [NDISK*WORD_W-1:0] words,
  output logic [WORD_W-1:0]       folded
);
  logic [WORD_W-1:0] chain [NDISK+1];
  assign chain[0] = '0;
  for (genvar i = 0; i < NDISK; i++) begin : g_fold
    assign chain[i+1] = chain[i] ^ (sel[i] ? words[i*WORD_W +: WORD_W] : '0);
  end
  assign folded = chain[NDISK];
endmodule

// File: rtl/raid5_rmw_engine.sv
module raid5_rmw_engine #(
  parameter int NDISK    = 5,
  parameter int WORD_W   = 32,
  parameter int STRIPE_W = 16,
  localparam int DSK_W   = $clog2(NDISK),
  localparam int SLOT_W  = (NDISK > 2) ? $clog2(NDISK - 1) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_write,
  input  logic [STRIPE_W-1:0]     cmd_stripe,
  input  logic [SLOT_W-1:0]       cmd_slot,
  input  logic [WORD_W-1:0]       cmd_wdata,
  output logic                    cmd_done,
  output logic [WORD_W-1:0]       cmd_rdata,
  input  logic                    deg_en,
  input  logic [DSK_W-1:0]        deg_disk,
  output logic [NDISK-1:0]        disk_req,
  output logic                    disk_we,
  output logic [STRIPE_W-1:0]     disk_row,
  output logic [NDISK*WORD_W-1:0] disk_wdata,
  input  logic [NDISK-1:0]        disk_ack,
  input  logic [NDISK*WORD_W-1:0] disk_rdata
);
  import raid5_rmw_pkg::*;

  eng_state_t          state_q;
  logic [NDISK-1:0]    pend_q, wrmask_q;
  logic [WORD_W-1:0]   acc_q, data_q, rdout_q;
  logic [DSK_W-1:0]    par_q;
  logic [STRIPE_W-1:0] row_q;
  logic                done_q;

  logic [DSK_W-1:0]  map_par, map_dat;
  logic [NDISK-1:0]  plan_rd, plan_wr;
  logic [NDISK-1:0]  hit, left;
  logic [WORD_W-1:0] fold;

  raid5_layout #(.NDISK(NDISK), .STRIPE_W(STRIPE_W)) u_layout (
    .stripe(cmd_stripe), .slot(cmd_slot),
    .par_disk(map_par), .data_disk(map_dat)
  );

  raid5_opplan #(.NDISK(NDISK)) u_plan (
    .is_write(cmd_write), .deg_en(deg_en), .deg_disk(deg_disk),
    .par_disk(map_par), .data_disk(map_dat),
    .rd_mask(plan_rd), .wr_mask(plan_wr)
  );

  assign hit  = pend_q & disk_ack;
  assign left = pend_q & ~disk_ack;

  raid5_xorfold #(.NDISK(NDISK), .WORD_W(WORD_W)) u_fold (
    .sel(hit), .words(disk_rdata), .folded(fold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      wrmask_q <= '0;
      acc_q    <= '0;
      data_q   <= '0;
      rdout_q  <= '0;
      par_q    <= '0;
      row_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            row_q    <= cmd_stripe;
            data_q   <= cmd_wdata;
            par_q    <= map_par;
            wrmask_q <= plan_wr;
            acc_q    <= cmd_write ? cmd_wdata : '0;
            if (plan_rd != '0) begin
              pend_q  <= plan_rd;
              state_q <= ST_RD;
            end else begin
              pend_q  <= plan_wr;
              state_q <= ST_WR;
            end
          end
        end
        ST_RD: begin
          acc_q  <= acc_q ^ fold;
          pend_q <= left;
          if (left == '0) begin
            if (wrmask_q != '0) begin
              pend_q  <= wrmask_q;
              state_q <= ST_WR;
            end else begin
              rdout_q <= acc_q ^ fold;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WR: begin
          pend_q <= left;
          if (left == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign cmd_done  = done_q;
  assign cmd_rdata = rdout_q;
  assign disk_req  = pend_q;
  assign disk_we   = (state_q == ST_WR);
  assign disk_row  = row_q;

  for (genvar i = 0; i < NDISK; i++) begin : g_wd
    assign disk_wdata[i*WORD_W +: WORD_W] = (DSK_W'(i) == par_q) ? acc_q : data_q;
  end
endmodule

// File: rtl/raid5_rmw_checker.sv
module raid5_rmw_checker #(
  parameter int NDISK  = 5,
  localparam int DSK_W = $clog2(NDISK)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_ready,
  input logic             cmd_done,
  input logic [NDISK-1:0] disk_req,
  input logic             disk_we,
  input logic [NDISK-1:0] disk_ack,
  input logic             deg_en,
  input logic [DSK_W-1:0] deg_disk
);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (disk_req == '0));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);

  p_req_held_r12: assert property (@(posedge clk) disable iff (rst)
    ((disk_req & ~disk_ack) != '0) |=>
      ((disk_req & $past(disk_req & ~disk_ack)) == $past(disk_req & ~disk_ack)));

  p_dir_stable_r12: assert property (@(posedge clk) disable iff (rst)
    ((disk_req & ~disk_ack) != '0) |=> $stable(disk_we));

  p_write_after_reads_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(disk_we) |-> ($past(disk_req & ~disk_ack) == '0));

  p_pair_only_r3: assert property (@(posedge clk) disable iff (rst)
    (!deg_en && disk_req != '0) |-> ($countones(disk_req) <= 2));

  p_failed_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (deg_en && int'(deg_disk) < NDISK) |-> ((disk_req & (NDISK'(1) << deg_disk)) == '0));
endmodule

bind raid5_rmw_engine raid5_rmw_checker #(.NDISK(NDISK)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
  .disk_req(disk_req), .disk_we(disk_we), .disk_ack(disk_ack),
  .deg_en(deg_en), .deg_disk(deg_disk)
);

// File: tb/raid5_rmw_engine_bench.sv
module raid5_rmw_engine_bench;
  localparam int N = 5;
  localparam int W = 32;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [SW-1:0] cmd_stripe = '0;
  logic [1:0]    cmd_slot = '0;
  logic [W-1:0]  cmd_wdata = '0;
  logic          cmd_ready, cmd_done;
  logic [W-1:0]  cmd_rdata;
  logic          deg_en = 1'b0;
  logic [2:0]    deg_disk = '0;
  logic [N-1:0]  disk_req, disk_ack;
  logic          disk_we;
  logic [SW-1:0] disk_row;
  logic [N*W-1:0] disk_wdata, disk_rdata;

  raid5_rmw_engine #(.NDISK(N), .WORD_W(W), .STRIPE_W(SW)) u_raid5_rmw_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_stripe(cmd_stripe), .cmd_slot(cmd_slot),
    .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .deg_en(deg_en), .deg_disk(deg_disk), .disk_req(disk_req),
    .disk_we(disk_we), .disk_row(disk_row), .disk_wdata(disk_wdata),
    .disk_ack(disk_ack), .disk_rdata(disk_rdata)
  );

  typedef struct {
    logic [N-1:0] rdm;
    logic [N-1:0] wrm;
    bit           is_rd;
    logic [W-1:0] rdv;
    int           row;
    int           nrd;
    string        tag;
  } exp_t;

  exp_t q[$];
  logic [W-1:0] mem [N][16];
  logic [W-1:0] sh  [N][16];
  int total = 0, bad = 0, pushed = 0, finished = 0, cyc = 0;
  int cnt [N];
  logic [N-1:0] obs_rd = '0, obs_wr = '0;
  int rd_acks = 0;
  bit order_bad = 0, fail_touch = 0, prev_done = 0;

  task automatic check(bit ok, string what, logic [W-1:0] got, logic [W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got %h exp %h", what, got, expv);
    end
  endtask

  function automatic int par_of(int s); return N - 1 - (s % N); endfunction
  function automatic int phys_of(int s, int k); return (k < par_of(s)) ? k : k + 1; endfunction

  // monitor and disk models
  always @(negedge clk) begin
    if (rst) begin
      disk_ack = '0;
      disk_rdata = '0;
      for (int i = 0; i < N; i++) cnt[i] = 0;
    end else begin
      if (disk_req != '0) begin
        if (disk_we) begin
          obs_wr |= disk_req;
          if (q.size() > 0 && rd_acks < q[0].nrd) order_bad = 1;
        end else obs_rd |= disk_req;
        if (deg_en && disk_req[deg_disk]) fail_touch = 1;
      end
      if (cmd_done && prev_done) check(0, "R6 done lasted two cycles", 1, 0);
      if (cmd_done) begin
        if (q.size() == 0) check(0, "R6 done without operation", 1, 0);
        else begin
          exp_t e;
          bit memok;
          e = q.pop_front();
          check(obs_rd == e.rdm, {e.tag, " R1 R2 read disk set"}, W'(obs_rd), W'(e.rdm));
          check(obs_wr == e.wrm, {e.tag, " R3 write disk set"}, W'(obs_wr), W'(e.wrm));
          check(!order_bad, {e.tag, " R4 write before read responses"}, W'(order_bad), 0);
          check(!fail_touch, {e.tag, " R11 failed disk requested"}, W'(fail_touch), 0);
          if (e.is_rd) check(cmd_rdata == e.rdv, {e.tag, " returned word"}, cmd_rdata, e.rdv);
          memok = 1;
          for (int d = 0; d < N; d++) if (mem[d][e.row] !== sh[d][e.row]) memok = 0;
          check(memok, {e.tag, " R5 disk contents after op"}, mem[par_of(e.row)][e.row],
                sh[par_of(e.row)][e.row]);
          finished++;
        end
        obs_rd = '0; obs_wr = '0; rd_acks = 0; order_bad = 0; fail_touch = 0;
      end
      prev_done = cmd_done;
      for (int i = 0; i < N; i++) begin
        if (disk_ack[i]) disk_ack[i] = 1'b0;
        else if (disk_req[i]) begin
          cnt[i]++;
          if (cnt[i] >= 1 + (i + int'(disk_row[3:0])) % 3) begin
            cnt[i] = 0;
            disk_ack[i] = 1'b1;
            if (disk_we) mem[i][disk_row[3:0]] = disk_wdata[i*W +: W];
            else begin
              disk_rdata[i*W +: W] = mem[i][disk_row[3:0]];
              rd_acks++;
            end
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired got %0d exp done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_op(bit wr, int s, int k, logic [W-1:0] wd, string tag, bit inject = 0);
    exp_t e;
    int p, ph, f;
    logic [W-1:0] x;
    logic [N-1:0] ohp, ohd;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    p = par_of(s); ph = phys_of(s, k); f = deg_en ? int'(deg_disk) : -1;
    ohp = N'(1) << p; ohd = N'(1) << ph;
    e.row = s; e.is_rd = !wr; e.tag = tag; e.rdv = '0; e.rdm = '0; e.wrm = '0;
    if (!wr) begin
      if (f == ph) begin
        e.rdm = ~ohd; x = '0;
        for (int d = 0; d < N; d++) if (d != ph) x ^= sh[d][s];
        e.rdv = x;
      end else begin
        e.rdm = ohd; e.rdv = sh[ph][s];
      end
    end else if (f == p) begin
      e.wrm = ohd; sh[ph][s] = wd;
    end else if (f == ph) begin
      e.rdm = ~ohd & ~ohp; e.wrm = ohp; x = wd;
      for (int d = 0; d < N; d++) if (d != ph && d != p) x ^= sh[d][s];
      sh[p][s] = x;
    end else begin
      e.rdm = ohd | ohp; e.wrm = ohd | ohp;
      sh[p][s] = sh[p][s] ^ sh[ph][s] ^ wd;
      sh[ph][s] = wd;
    end
    e.nrd = $countones(e.rdm);
    q.push_back(e); pushed++;
    cmd_valid = 1; cmd_write = wr; cmd_stripe = SW'(s); cmd_slot = 2'(k); cmd_wdata = wd;
    @(negedge clk);
    check(cmd_ready == 0, {tag, " R6 ready low while busy"}, W'(cmd_ready), 0);
    if (inject) begin
      cmd_write = 1; cmd_stripe = 16'd7; cmd_slot = 2'd2; cmd_wdata = 32'hBAD0BAD0;
      @(negedge clk);
      @(negedge clk);
    end
    cmd_valid = 0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < 16; r++) begin
      logic [W-1:0] x;
      x = '0;
      for (int d = 0; d < N; d++) begin
        if (d != par_of(r)) begin
          mem[d][r] = 32'hA5A50000 ^ (d * 32'h01010101) ^ (r * 32'h00001357);
          x ^= mem[d][r];
        end
      end
      mem[par_of(r)][r] = x;
      for (int d = 0; d < N; d++) sh[d][r] = mem[d][r];
    end
    repeat (3) @(negedge clk);
    check(cmd_ready == 1, "R12 reset ready", W'(cmd_ready), 1);
    check(disk_req == '0, "R12 reset requests", W'(disk_req), 0);
    check(cmd_done == 0, "R12 reset done", W'(cmd_done), 0);
    rst = 0;
    run_op(1, 0, 0, 32'h11112222, "R1 R5 stripe0 slot0");
    run_op(1, 3, 1, 32'h33334444, "R2 stripe3 slot1 skips parity");
    run_op(1, 3, 0, 32'h55556666, "R1 stripe3 slot0");
    run_op(1, 5, 3, 32'h77778888, "R1 stripe5 slot3");
    run_op(0, 3, 3, '0, "R7 read stripe3 slot3");
    run_op(0, 3, 1, '0, "R7 read back written word");
    run_op(1, 2, 1, 32'h9999AAAA, "R6 busy refusal", 1);
    check(finished == pushed, "R6 one done per accepted op", W'(finished), W'(pushed));
    check(mem[3][7] == sh[3][7], "R6 refused write left disk alone", mem[3][7], sh[3][7]);
    @(negedge clk); deg_en = 1; deg_disk = 3'd2;
    run_op(0, 3, 1, '0, "R8 rebuild failed disk");
    run_op(1, 3, 1, 32'hCAFEF00D, "R9 write to failed disk");
    run_op(0, 3, 1, '0, "R8 R9 rebuilt word after parity-only write");
    run_op(1, 3, 2, 32'h0BADCAFE, "R3 healthy write while degraded");
    @(negedge clk); deg_disk = 3'd4;
    run_op(1, 0, 1, 32'h12345678, "R10 parity disk failed");
    run_op(0, 0, 1, '0, "R10 R7 data read after parity loss");
    @(negedge clk); deg_en = 0;
    run_op(1, 8, 2, 32'hFEEDBEEF, "R1 stripe8 parity disk1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule